// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one warp-wide load or store, made of 32 per-thread byte addresses and a mask of active threads. It turns that access into the smallest set of aligned 128-byte block requests for the memory system. Each address is first classified against a unified 40-bit map. A fixed 16 MB shared window and the 16 MB local window directly above it are recognised. Every other address is global. Threads whose accesses fall in the same space and the same 128-byte block are merged into one request, and that request carries a 32-bit mask of the threads it serves.

One warp is accepted at a time over a valid/ready handshake on the input side. Its requests then leave one per cycle over a valid/ready handshake on the output side, and the block accepts the next warp once the last request has been taken. A narrow mode models 32-bit addressing: only the low 32 bits of each address are used, so every access falls in the lowest 4 GB.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is asserted and right after it, `insnReady` is 1 and `blkValid` is 0.
- R2: `blkSpace` is 1 (shared) for an effective address in [SHARED_BASE, SHARED_BASE+16 MB), 2 (local) for [SHARED_BASE+16 MB, SHARED_BASE+32 MB), and 0 (global) for any other address. The default SHARED_BASE is 0x00_0100_0000.
- R3: For a global request, `blkAddr` is the effective address with bits 6:0 cleared. For a shared or local request, `blkAddr` is the offset from the window's start with bits 6:0 cleared.
- R4: Each request's `blkMask` holds exactly the pending active threads that share the leader's space and 128-byte block. A warp produces one request per distinct (space, block) pair among its active threads, and none after that.
- R5: The leader of each request is the lowest-numbered thread still pending. It is the lowest set bit of `blkMask`, and leaders rise from one request to the next.
- R6: While `blkValid` is 1 and `blkReady` is 0, `blkSpace`, `blkAddr` and `blkMask` stay unchanged.
- R7: An inactive thread's address has no effect on any request, and its bit is never set in `blkMask`.
- R8: A warp accepted with an all-zero mask issues no request, and `insnReady` is 1 again in the next cycle.
- R9: When `insnNarrow` is 1, bits 39:32 of every thread address are treated as zero.
- R10: `insnReady` is 0 from the cycle after a warp with active threads is accepted until its last request is taken. A warp offered while `insnReady` is 0 is not accepted. The first request appears the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insnValid | input | 1 | A warp access is offered |
| insnReady | output | 1 | The block can accept a warp |
| insnAddr | input | LANES*ADDR_W | Thread addresses, thread i in bits [i*40 +: 40] |
| insnMask | input | LANES | Active-thread mask, bit i for thread i |
| insnNarrow | input | 1 | 32-bit addressing mode |
| blkValid | output | 1 | A block request is presented |
| blkReady | input | 1 | The memory side takes the request |
| blkSpace | output | 2 | 0 global, 1 shared, 2 local |
| blkAddr | output | ADDR_W | Aligned block address or window offset |
| blkMask | output | LANES | Threads served by this request |

## Verification
The assertions assume the memory side follows the handshake and the warp side offers a warp only through `insnValid`. They also assume reset is held across at least one clock edge. The stall-hold and coverage properties depend on those assumptions. The stimulus only changes inputs on the falling edge, and it varies `blkReady` with fixed stall patterns. Some runs keep `insnValid` high with different data while a warp drains, which exercises refused offers without breaking the handshake. Inactive threads are given out-of-range addresses, so any leak of them shows up in the requests.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [1:0] {
    SPACE_GLOBAL = 2'd0,
    SPACE_SHARED = 2'd1,
    SPACE_LOCAL  = 2'd2
  } space_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new warp
    logic retire;  // drop the threads served by the current request
  } strobe_t;
endpackage

// File: rtl/wmc_steer.sv
module wmc_steer
  import wmc_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFF_W = 7,
  parameter int WIN_BITS = 24,
  parameter logic [ADDR_W-1:0] SHARED_BASE = ADDR_W'(32'h0100_0000),
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output space_e            space,
  output logic [BLK_W-1:0]  blk
);
  localparam logic [ADDR_W-1:0] WinSize = ADDR_W'(1) << WIN_BITS;

  logic [ADDR_W-1:0] relShared;
  logic [ADDR_W-1:0] relLocal;

  // addresses below the base wrap to large values and land in global
  assign relShared = addr - SHARED_BASE;
  assign relLocal  = relShared - WinSize;

  always_comb begin
    if (relShared < WinSize) begin
      space = SPACE_SHARED;
      blk   = relShared[ADDR_W-1:OFF_W];
    end else if (relLocal < WinSize) begin
      space = SPACE_LOCAL;
      blk   = relLocal[ADDR_W-1:OFF_W];
    end else begin
      space = SPACE_GLOBAL;
      blk   = addr[ADDR_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/wmc_datapath.sv
module wmc_datapath
  import wmc_pkg::*;
#(
  parameter int LANES = 32,
  parameter int ADDR_W = 40,
  parameter int NARROW_W = 32,
  parameter int OFF_W = 7,
  parameter int WIN_BITS = 24,
  parameter logic [ADDR_W-1:0] SHARED_BASE = ADDR_W'(32'h0100_0000),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int LIDX_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [LANES*ADDR_W-1:0] insnAddr,
  input  logic [LANES-1:0]        insnMask,
  input  logic                    insnNarrow,
  output logic                    busy,
  output space_e                  blkSpace,
  output logic [ADDR_W-1:0]       blkAddr,
  output logic [LANES-1:0]        blkMask
);
  logic [ADDR_W-1:0] addrQ [LANES];
  logic [LANES-1:0]  pendQ;
  space_e            laneSpace [LANES];
  logic [BLK_W-1:0]  laneBlk [LANES];
  logic [LANES-1:0]  matchVec;
  logic [LIDX_W-1:0] leadIdx;
  space_e            leadSpace;
  logic [BLK_W-1:0]  leadBlk;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] rawAddr;
    logic [ADDR_W-1:0] effAddr;

    assign rawAddr = insnAddr[g*ADDR_W +: ADDR_W];
    assign effAddr = insnNarrow ? ADDR_W'(rawAddr[NARROW_W-1:0]) : rawAddr;

    always_ff @(posedge clk) begin
      if (stb.load) addrQ[g] <= effAddr;
    end

    wmc_steer #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WIN_BITS(WIN_BITS), .SHARED_BASE(SHARED_BASE)
    ) u_steer (
      .addr (addrQ[g]),
      .space(laneSpace[g]),
      .blk  (laneBlk[g])
    );

    assign matchVec[g] = pendQ[g] && (laneSpace[g] == leadSpace) && (laneBlk[g] == leadBlk);
  end

  // lowest pending thread leads the next request
  always_comb begin
    leadIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) leadIdx = LIDX_W'(i);
    end
  end

  assign leadSpace = laneSpace[leadIdx];
  assign leadBlk   = laneBlk[leadIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else if (stb.load) begin
      pendQ <= insnMask;
    end else if (stb.retire) begin
      pendQ <= pendQ & ~matchVec;
    end
  end

  assign busy     = |pendQ;
  assign blkSpace = leadSpace;
  assign blkAddr  = {leadBlk, {OFF_W{1'b0}}};
  assign blkMask  = matchVec;
endmodule

// File: rtl/wmc_ctrl.sv
module wmc_ctrl
  import wmc_pkg::*;
(
  input  logic    insnValid,
  input  logic    blkReady,
  input  logic    busy,
  output logic    insnReady,
  output logic    blkValid,
  output strobe_t stb
);
  assign insnReady  = !busy;
  assign blkValid   = busy;
  assign stb.load   = insnValid && !busy;
  assign stb.retire = busy && blkReady;
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import wmc_pkg::*;
#(
  parameter int LANES = 32,
  parameter int ADDR_W = 40,
  parameter int NARROW_W = 32,
  parameter int BLK_BYTES = 128,
  parameter int WIN_BITS = 24,
  parameter logic [ADDR_W-1:0] SHARED_BASE = ADDR_W'(32'h0100_0000),
  localparam int OFF_W = $clog2(BLK_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    insnValid,
  output logic                    insnReady,
  input  logic [LANES*ADDR_W-1:0] insnAddr,
  input  logic [LANES-1:0]        insnMask,
  input  logic                    insnNarrow,
  output logic                    blkValid,
  input  logic                    blkReady,
  output logic [1:0]              blkSpace,
  output logic [ADDR_W-1:0]       blkAddr,
  output logic [LANES-1:0]        blkMask
);
  strobe_t stb;
  logic    busy;
  space_e  spaceOut;

  wmc_ctrl u_ctrl (
    .insnValid(insnValid),
    .blkReady (blkReady),
    .busy     (busy),
    .insnReady(insnReady),
    .blkValid (blkValid),
    .stb      (stb)
  );

  wmc_datapath #(
    .LANES(LANES), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .OFF_W(OFF_W),
    .WIN_BITS(WIN_BITS), .SHARED_BASE(SHARED_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .insnAddr  (insnAddr),
    .insnMask  (insnMask),
    .insnNarrow(insnNarrow),
    .busy      (busy),
    .blkSpace  (spaceOut),
    .blkAddr   (blkAddr),
    .blkMask   (blkMask)
  );

  assign blkSpace = spaceOut;
endmodule

// File: rtl/wmc_checker.sv
module wmc_checker #(
  parameter int LANES = 32,
  parameter int ADDR_W = 40,
  parameter int OFF_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              insnValid,
  input logic              insnReady,
  input logic [LANES-1:0]  insnMask,
  input logic              blkValid,
  input logic              blkReady,
  input logic [1:0]        blkSpace,
  input logic [ADDR_W-1:0] blkAddr,
  input logic [LANES-1:0]  blkMask
);
  logic [LANES-1:0] acceptedMask;
  logic [LANES-1:0] servedMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptedMask <= '0;
      servedMask   <= '0;
    end else if (insnValid && insnReady) begin
      acceptedMask <= insnMask;
      servedMask   <= '0;
    end else if (blkValid && blkReady) begin
      servedMask <= servedMask | blkMask;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    blkValid && !blkReady |=> blkValid && $stable(blkMask) && $stable(blkAddr) && $stable(blkSpace));

  p_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> blkMask != '0);

  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> (blkMask & servedMask) == '0);

  p_cover_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(insnReady) |-> servedMask == acceptedMask);

  p_space_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> blkSpace != 2'd3);

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> blkAddr[OFF_W-1:0] == '0);

  p_active_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> (blkMask & ~acceptedMask) == '0);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> !insnReady);
endmodule

bind warp_coalescer wmc_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .insnValid(insnValid),
  .insnReady(insnReady),
  .insnMask (insnMask),
  .blkValid (blkValid),
  .blkReady (blkReady),
  .blkSpace (blkSpace),
  .blkAddr  (blkAddr),
  .blkMask  (blkMask)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int LANES = 32;
  localparam int ADDR_W = 40;
  localparam logic [39:0] SB  = 40'h00_0100_0000;
  localparam logic [39:0] WIN = 40'h00_0100_0000;

  typedef struct packed {
    logic [3:0]  pat;
    logic [39:0] base;
    logic [31:0] mask;
    logic        narrow;
    logic [3:0]  stall;
  } vec_t;

  // pattern, base, active mask, narrow, stall period
  localparam vec_t VECS [13] = '{
    '{4'd0, 40'h12_3456_7800, 32'hFFFF_FFFF, 1'b0, 4'd0},  // one block
    '{4'd0, 40'h12_3456_7840, 32'hFFFF_FFFF, 1'b0, 4'd2},  // straddles two blocks
    '{4'd1, 40'h00_8000_0000, 32'hFFFF_FFFF, 1'b0, 4'd5},  // 32 blocks
    '{4'd2, 40'h03_0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd3},  // 16 blocks
    '{4'd3, 40'h07_0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd0},  // three spaces
    '{4'd4, 40'h05_0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd0},  // descending addresses
    '{4'd5, 40'h09_0000_0000, 32'hA5A5_0F0F, 1'b0, 4'd4},  // sparse mask
    '{4'd6, 40'h00_0000_0000, 32'hFFFF_FFFF, 1'b1, 4'd0},  // narrow into shared
    '{4'd6, 40'h00_0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd0},  // wide stays global
    '{4'd7, 40'h00_0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd6},  // window edges
    '{4'd1, 40'h00_8000_0000, 32'h8000_0001, 1'b0, 4'd0},  // end threads only
    '{4'd0, 40'h12_3456_7800, 32'h0000_0000, 1'b0, 4'd0},  // nobody active
    '{4'd3, 40'h07_0000_0000, 32'h0000_0002, 1'b0, 4'd0}   // single thread
  };

  logic                    clk;
  logic                    rstN;
  logic                    insnValid;
  logic                    insnReady;
  logic [LANES*ADDR_W-1:0] insnAddr;
  logic [LANES-1:0]        insnMask;
  logic                    insnNarrow;
  logic                    blkValid;
  logic                    blkReady;
  logic [1:0]              blkSpace;
  logic [ADDR_W-1:0]       blkAddr;
  logic [LANES-1:0]        blkMask;

  logic [39:0] addrs [LANES];
  int checks = 0;
  int fails = 0;

  warp_coalescer u_dut (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .insnReady(insnReady),
    .insnAddr(insnAddr), .insnMask(insnMask), .insnNarrow(insnNarrow),
    .blkValid(blkValid), .blkReady(blkReady), .blkSpace(blkSpace),
    .blkAddr(blkAddr), .blkMask(blkMask)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // expected space and block for an address, straight from R2, R3, R9
  function automatic logic [41:0] refMap(input logic [39:0] a, input logic nar);
    logic [39:0] e;
    e = nar ? {8'h00, a[31:0]} : a;
    if (e >= SB && e < SB + WIN) return {2'd1, (e - SB) & ~40'h7F};
    if (e >= SB + WIN && e < SB + WIN + WIN) return {2'd2, (e - SB - WIN) & ~40'h7F};
    return {2'd0, e & ~40'h7F};
  endfunction

  function automatic logic [39:0] genAddr(input vec_t v, input int lane);
    logic [39:0] l;
    l = 40'(lane);
    if (!v.mask[lane]) return 40'hEE_0100_0000 + (l << 12);  // junk for inactive threads
    case (v.pat)
      4'd0: return v.base + (l << 2);
      4'd1: return v.base + (l << 7);
      4'd2: return v.base + (l << 6);
      4'd3: case (lane % 3)
              0: return v.base + (l << 2);
              1: return SB + (l << 2);
              default: return SB + WIN + (l << 2);
            endcase
      4'd4: return v.base + ((40'd31 - l) << 7);
      4'd5: return v.base + ((l % 4) << 2) + ((l / 8) << 7);
      4'd6: return 40'hA5_0000_0000 | (SB + (l << 2));
      default: case (lane % 8)
              0: return SB - 40'd4;
              1: return SB;
              2: return SB + WIN - 40'd1;
              3: return SB + WIN;
              4: return SB + WIN + WIN - 40'd1;
              5: return SB + WIN + WIN;
              6: return SB + WIN - 40'd128;
              default: return SB + 40'd130;
            endcase
    endcase
  endfunction

  task automatic runWarp(input vec_t v, input bit intrude);
    logic [31:0] pend;
    logic [31:0] emask;
    logic [41:0] key;
    logic [31:0] heldMask;
    logic [39:0] heldAddr;
    int lead;
    int prevLead;
    int k;
    for (int i = 0; i < LANES; i++) begin
      addrs[i] = genAddr(v, i);
      insnAddr[i*ADDR_W +: ADDR_W] = addrs[i];
    end
    @(negedge clk);
    chk("R10 ready before offer", 64'(insnReady), 64'd1);
    insnMask = v.mask;
    insnNarrow = v.narrow;
    insnValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (intrude && v.mask != 0) begin
      insnMask = ~v.mask;
      insnNarrow = ~v.narrow;
    end else begin
      insnValid = 1'b0;
    end
    pend = v.mask;
    k = 0;
    prevLead = -1;
    while (pend != 0 && k < 400) begin
      lead = 0;
      for (int j = LANES - 1; j >= 0; j--) if (pend[j]) lead = j;
      key = refMap(addrs[lead], v.narrow);
      emask = '0;
      for (int j = 0; j < LANES; j++)
        if (pend[j] && refMap(addrs[j], v.narrow) == key) emask[j] = 1'b1;
      blkReady = (v.stall == 0) || ((k % int'(v.stall)) != 0);
      k++;
      chk("R10 request follows accept", 64'(blkValid), 64'd1);
      chk("R4 thread mask", 64'(blkMask), 64'(emask));
      chk("R2 space code", 64'(blkSpace), 64'(key[41:40]));
      chk("R3 block address", 64'(blkAddr), 64'(key[39:0]));
      chk("R7 inactive excluded", 64'(blkMask & ~v.mask), 64'd0);
      chk("R5 leader rises", 64'(lead > prevLead), 64'd1);
      if (v.narrow) chk("R9 upper bits dropped", 64'(blkAddr[39:32]), 64'd0);
      if (blkReady) begin
        pend = pend & ~emask;
        prevLead = lead;
        @(posedge clk);
        @(negedge clk);
      end else begin
        heldMask = blkMask;
        heldAddr = blkAddr;
        @(posedge clk);
        @(negedge clk);
        chk("R6 mask held", 64'(blkMask), 64'(heldMask));
        chk("R6 addr held", 64'(blkAddr), 64'(heldAddr));
      end
    end
    blkReady = 1'b0;
    if (v.mask == 0) chk("R8 empty warp", 64'(blkValid), 64'd0);
    else chk("R4 no extra request", 64'(blkValid), 64'd0);
    chk("R10 ready after drain", 64'(insnReady), 64'd1);
    insnValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    insnValid = 1'b0;
    insnAddr = '0;
    insnMask = '0;
    insnNarrow = 1'b0;
    blkReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", 64'(insnReady), 64'd1);
    chk("R1 idle in reset", 64'(blkValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 64'(blkValid), 64'd0);

    for (int i = 0; i < 13; i++) runWarp(VECS[i], (i == 2) || (i == 6));

    // reset in the middle of a warp
    for (int i = 0; i < LANES; i++) insnAddr[i*ADDR_W +: ADDR_W] = 40'h00_8000_0000 + 40'(i * 128);
    @(negedge clk);
    insnMask = '1;
    insnValid = 1'b1;
    blkReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insnValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 busy mid warp", 64'(insnReady), 64'd0);
    rstN = 1'b0;
    blkReady = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset clears requests", 64'(blkValid), 64'd0);
    chk("R1 reset restores ready", 64'(insnReady), 64'd1);
    rstN = 1'b1;
    runWarp(VECS[4], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule